// File: doc/BRIEF.md
# LED Matrix Row Scanner with Bit-Plane Modulation

This block drives a two-half LED matrix panel from a double-banked pixel store. It holds the panel dark until the pixel receiver signals its first completed frame. From then on it scans the panel one row pair at a time. For every row pair it reads each column from the store and presents one colour bit to the panel on each rising shift clock. The upper half of the panel gets row `n` and the lower half gets row `n + ROWS/2`. After all columns are shifted, it pulses the latch and then lights the row by pulling the active-low output enable low.

The same row pair is shifted once per intensity bit-plane, least significant plane first. The lit time doubles with each plane, so the panel shows binary-weighted intensity. The shift clock and all panel timing advance once every `DIV` system cycles.

Each pulse on the swap input marks a newly completed frame in the other bank. The scanner takes up the most recent bank only at the start of a frame, so a frame is never shown half from one bank and half from the other.

Top module: `hub75_scanner`

## Requirements
- R1: After reset, `oe_n_o` is 1, `sclk_o` and `lat_o` are 0 and `row_o` is 0. They stay that way, with no shift clock edge, no latch and no lit row, until the first pulse on `swap_i`.
- R2: Between two consecutive latch pulses there are exactly `COLS` rising edges of `sclk_o`, and `oe_n_o` is 1 at every one of them.
- R3: Within one row shift, consecutive rising edges of `sclk_o` are exactly `DIV` system cycles apart.
- R4: The store is read with one cycle of latency: the `rd_top_i`/`rd_bot_i` word for the address on `rd_bank_o`/`rd_row_o`/`rd_col_o` arrives one cycle later. A pixel word is `{R, G, B}`, each channel `PLANES` bits wide with R in the top bits. At the k-th rising `sclk_o` of a shift for plane p, `rgb_top_o[2]`, `[1]` and `[0]` carry bit p of R, G and B of column k of the upper row. `rgb_bot_o` carries the same bits for the lower row.
- R5: Every window with `oe_n_o` low comes after a latch pulse that follows the end of the previous window, and `lat_o` is never 1 while `oe_n_o` is 0.
- R6: For each row pair the windows come in plane order 0 to `PLANES-1`. The window for plane p lasts exactly `OE_BASE * DIV * 2^p` system cycles.
- R7: `row_o` steps through 0 to `ROWS/2-1` and wraps, advancing after all planes of a row pair. It changes only while `oe_n_o` is 1.
- R8: The first swap pulse starts scanning from bank 0. Each later pulse toggles the latest bank, and the latest bank becomes `rd_bank_o` at the next frame start only. Two pulses within one frame therefore leave the bank unchanged. `rd_bank_o` changes only when `rd_row_o` and `rd_col_o` are both 0.
- R9: One frame takes `ROWS/2 * DIV * (PLANES*(COLS+2) + OE_BASE*(2^PLANES-1))` system cycles. With the defaults this is 262,656 cycles, about 190 frames per second at 50 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| swap_i | input | 1 | One-cycle pulse: a new frame is complete in the other bank |
| rd_bank_o | output | 1 | Store bank being scanned |
| rd_row_o | output | $clog2(ROWS/2) | Row pair read address |
| rd_col_o | output | $clog2(COLS) | Column read address |
| rd_top_i | input | 3*PLANES | Upper-half pixel word, one cycle after the address |
| rd_bot_i | input | 3*PLANES | Lower-half pixel word, one cycle after the address |
| rgb_top_o | output | 3 | Upper-half R, G, B data bits |
| rgb_bot_o | output | 3 | Lower-half R, G, B data bits |
| sclk_o | output | 1 | Panel shift clock |
| lat_o | output | 1 | Panel latch pulse |
| oe_n_o | output | 1 | Panel output enable, active low |
| row_o | output | $clog2(ROWS/2) | Lit row pair address |

## Verification
The store model returns an arithmetic hash of bank, full row and column. Every plane bit, channel and half of a column therefore differs from its neighbours, so a swapped plane index, channel order, half or column shows up as a mismatch. Swap pulses come in four patterns, each telling apart a different bank policy: none before scanning, one in mid-frame (adopted one frame later), two within one frame (no net change) and one more later. Window lengths, the row and plane order and the frame-to-frame period are measured in cycles against the closed-form formula on a small panel, across four whole frames.

// File: rtl/hub75_pkg.sv
package hub75_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_LATCH,
    ST_SHOW,
    ST_BLANK
  } scan_state_t;

endpackage

// File: rtl/hub75_phase.sv
module hub75_phase #(
  parameter int DIV = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  output logic [$clog2(DIV)-1:0] ph,
  output logic                   ph_last
);
  localparam int PW = $clog2(DIV);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph <= '0;
    end else if (ph == PW'(DIV-1)) begin
      ph <= '0;
    end else begin
      ph <= ph + PW'(1);
    end
  end

  assign ph_last = run && (ph == PW'(DIV-1));

endmodule

// File: rtl/hub75_plane_pick.sv
module hub75_plane_pick #(
  parameter int PLANES = 4
) (
  input  logic [3*PLANES-1:0]                         pix,
  input  logic [(PLANES > 1 ? $clog2(PLANES) : 1)-1:0] plane,
  output logic [2:0]                                  rgb
);
  // channel 2 = red (top bits), 1 = green, 0 = blue
  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    logic [PLANES-1:0] chan;
    assign chan    = pix[ch*PLANES +: PLANES];
    assign rgb[ch] = chan[plane];
  end

endmodule

// File: rtl/hub75_scan_seq.sv
module hub75_scan_seq
  import hub75_pkg::*;
#(
  parameter int COLS    = 64,
  parameter int ROWS    = 32,
  parameter int PLANES  = 4,
  parameter int OE_BASE = 256
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        swap_i,
  input  logic                                        ph_last,
  output scan_state_t                                 state_o,
  output logic [$clog2(COLS)-1:0]                     col_o,
  output logic [$clog2(ROWS/2)-1:0]                   row_o,
  output logic [(PLANES > 1 ? $clog2(PLANES) : 1)-1:0] plane_o,
  output logic                                        bank_o
);
  localparam int CW  = $clog2(COLS);
  localparam int RAW = $clog2(ROWS/2);
  localparam int PLW = PLANES > 1 ? $clog2(PLANES) : 1;
  localparam int TW  = $clog2(OE_BASE) + PLANES + 1;

  scan_state_t    st;
  logic [CW-1:0]  col;
  logic [RAW-1:0] row;
  logic [PLW-1:0] plane;
  logic           bank;
  logic           latest;
  logic           pend;
  logic [TW-1:0]  tcnt;
  logic [TW-1:0]  win_len;
  logic           new_latest;

  assign new_latest = swap_i ? ~latest : latest;
  assign win_len    = TW'(OE_BASE) << plane;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      col    <= '0;
      row    <= '0;
      plane  <= '0;
      bank   <= 1'b0;
      latest <= 1'b1;
      pend   <= 1'b0;
      tcnt   <= '0;
    end else begin
      latest <= new_latest;
      if (swap_i) pend <= 1'b1;
      unique case (st)
        ST_IDLE: begin
          if (swap_i) begin
            st   <= ST_SHIFT;
            bank <= new_latest;
            pend <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (ph_last) begin
            if (col == CW'(COLS-1)) st <= ST_LATCH;
            else                    col <= col + CW'(1);
          end
        end
        ST_LATCH: begin
          if (ph_last) begin
            st   <= ST_SHOW;
            tcnt <= '0;
          end
        end
        ST_SHOW: begin
          if (ph_last) begin
            if (tcnt == win_len - TW'(1)) st <= ST_BLANK;
            else                          tcnt <= tcnt + TW'(1);
          end
        end
        ST_BLANK: begin
          if (ph_last) begin
            st  <= ST_SHIFT;
            col <= '0;
            if (plane == PLW'(PLANES-1)) begin
              plane <= '0;
              if (row == RAW'(ROWS/2-1)) begin
                row <= '0;
                if (pend || swap_i) begin
                  bank <= new_latest;
                  pend <= 1'b0;
                end
              end else begin
                row <= row + RAW'(1);
              end
            end else begin
              plane <= plane + PLW'(1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign state_o = st;
  assign col_o   = col;
  assign row_o   = row;
  assign plane_o = plane;
  assign bank_o  = bank;

endmodule

// File: rtl/hub75_scanner.sv
module hub75_scanner
  import hub75_pkg::*;
#(
  parameter int COLS    = 64,
  parameter int ROWS    = 32,
  parameter int PLANES  = 4,
  parameter int DIV     = 4,
  parameter int OE_BASE = 256
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      swap_i,
  output logic                      rd_bank_o,
  output logic [$clog2(ROWS/2)-1:0] rd_row_o,
  output logic [$clog2(COLS)-1:0]   rd_col_o,
  input  logic [3*PLANES-1:0]       rd_top_i,
  input  logic [3*PLANES-1:0]       rd_bot_i,
  output logic [2:0]                rgb_top_o,
  output logic [2:0]                rgb_bot_o,
  output logic                      sclk_o,
  output logic                      lat_o,
  output logic                      oe_n_o,
  output logic [$clog2(ROWS/2)-1:0] row_o
);
  localparam int PW  = $clog2(DIV);
  localparam int CW  = $clog2(COLS);
  localparam int RAW = $clog2(ROWS/2);
  localparam int PLW = PLANES > 1 ? $clog2(PLANES) : 1;

  initial begin
    if (DIV < 4) $error("DIV must be at least 4");
  end

  scan_state_t    st;
  logic [PW-1:0]  ph;
  logic           ph_last;
  logic [CW-1:0]  col;
  logic [RAW-1:0] row;
  logic [PLW-1:0] plane;
  logic           bank;
  logic [2:0]     pick_top;
  logic [2:0]     pick_bot;

  hub75_phase #(.DIV(DIV)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .run     (st != ST_IDLE),
    .ph      (ph),
    .ph_last (ph_last)
  );

  hub75_scan_seq #(
    .COLS(COLS), .ROWS(ROWS), .PLANES(PLANES), .OE_BASE(OE_BASE)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .swap_i  (swap_i),
    .ph_last (ph_last),
    .state_o (st),
    .col_o   (col),
    .row_o   (row),
    .plane_o (plane),
    .bank_o  (bank)
  );

  hub75_plane_pick #(.PLANES(PLANES)) u_pick_top (
    .pix (rd_top_i), .plane (plane), .rgb (pick_top)
  );

  hub75_plane_pick #(.PLANES(PLANES)) u_pick_bot (
    .pix (rd_bot_i), .plane (plane), .rgb (pick_bot)
  );

  assign rd_bank_o = bank;
  assign rd_row_o  = row;
  assign rd_col_o  = col;

  // Data is captured one cycle after the column address settles
  // (phase 1) and is clocked into the panel on the rising edge at
  // the second half of the slot.
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_o    <= 1'b0;
      lat_o     <= 1'b0;
      oe_n_o    <= 1'b1;
      row_o     <= '0;
      rgb_top_o <= '0;
      rgb_bot_o <= '0;
    end else begin
      sclk_o <= (st == ST_SHIFT) && (ph >= PW'(DIV/2));
      lat_o  <= (st == ST_LATCH);
      oe_n_o <= (st != ST_SHOW);
      if (st == ST_LATCH) row_o <= row;
      if (st == ST_SHIFT && ph == PW'(1)) begin
        rgb_top_o <= pick_top;
        rgb_bot_o <= pick_bot;
      end
    end
  end

endmodule

// File: rtl/hub75_scanner_chk.sv
module hub75_scanner_chk #(
  parameter int COLS    = 64,
  parameter int ROWS    = 32,
  parameter int PLANES  = 4,
  parameter int DIV     = 4,
  parameter int OE_BASE = 256
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      swap_i,
  input logic                      sclk_o,
  input logic                      lat_o,
  input logic                      oe_n_o,
  input logic [$clog2(ROWS/2)-1:0] row_o,
  input logic                      rd_bank_o,
  input logic [$clog2(ROWS/2)-1:0] rd_row_o,
  input logic [$clog2(COLS)-1:0]   rd_col_o
);
  localparam int UNIT = OE_BASE * DIV;

  logic started;
  int   low_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      low_len <= 0;
    end else begin
      if (swap_i) started <= 1'b1;
      low_len <= oe_n_o ? 0 : low_len + 1;
    end
  end

  a_r1_dark_until_swap: assert property (@(posedge clk) disable iff (rst)
    !started |-> (oe_n_o && !sclk_o && !lat_o));

  a_r2_dark_while_shift: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> oe_n_o);

  a_r5_latch_while_dark: assert property (@(posedge clk) disable iff (rst)
    lat_o |-> oe_n_o);

  a_r6_window_weight: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_n_o) |-> ((low_len % UNIT) == 0) && $onehot(low_len / UNIT)
                      && ((low_len / UNIT) < (1 << PLANES)));

  a_r7_row_moves_dark: assert property (@(posedge clk) disable iff (rst)
    !$stable(row_o) |-> oe_n_o);

  a_r8_bank_at_frame_start: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_bank_o) |-> (rd_row_o == '0) && (rd_col_o == '0));

endmodule

bind hub75_scanner hub75_scanner_chk #(
  .COLS(COLS), .ROWS(ROWS), .PLANES(PLANES), .DIV(DIV), .OE_BASE(OE_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .swap_i    (swap_i),
  .sclk_o    (sclk_o),
  .lat_o     (lat_o),
  .oe_n_o    (oe_n_o),
  .row_o     (row_o),
  .rd_bank_o (rd_bank_o),
  .rd_row_o  (rd_row_o),
  .rd_col_o  (rd_col_o)
);

// File: tb/tb_hub75_scanner.sv
module tb_hub75_scanner;
  localparam int COLS    = 8;
  localparam int ROWS    = 8;
  localparam int PLANES  = 4;
  localparam int DIV     = 4;
  localparam int OE_BASE = 2;
  localparam int RAW     = $clog2(ROWS/2);
  localparam int CW      = $clog2(COLS);
  localparam int FRAME_CYC = (ROWS/2) * DIV * (PLANES*(COLS+2) + OE_BASE*((1<<PLANES)-1));
  localparam int WINDOWS   = 4 * (ROWS/2) * PLANES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic swap = 1'b0;
  logic rd_bank;
  logic [RAW-1:0] rd_row;
  logic [CW-1:0]  rd_col;
  logic [3*PLANES-1:0] top_q, bot_q;
  logic [2:0] rgb_top, rgb_bot;
  logic sclk, lat, oe_n;
  logic [RAW-1:0] row;

  always #10 clk = ~clk;

  hub75_scanner #(
    .COLS(COLS), .ROWS(ROWS), .PLANES(PLANES), .DIV(DIV), .OE_BASE(OE_BASE)
  ) dut (
    .clk(clk), .rst(rst), .swap_i(swap),
    .rd_bank_o(rd_bank), .rd_row_o(rd_row), .rd_col_o(rd_col),
    .rd_top_i(top_q), .rd_bot_i(bot_q),
    .rgb_top_o(rgb_top), .rgb_bot_o(rgb_bot),
    .sclk_o(sclk), .lat_o(lat), .oe_n_o(oe_n), .row_o(row)
  );

  function automatic logic [3*PLANES-1:0] pix(int b, int r, int c);
    return (3*PLANES)'((b*1111 + r*203 + c*29 + 5) % 4096);
  endfunction

  // one-cycle-latency store model (R4)
  always_ff @(posedge clk) begin
    top_q <= pix(int'(rd_bank), int'(rd_row), int'(rd_col));
    bot_q <= pix(int'(rd_bank), int'(rd_row) + ROWS/2, int'(rd_col));
  end

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model state
  int  exp_row = 0, exp_plane = 0, exp_bank = 0;
  bit  m_latest = 1'b1, m_pend = 1'b0, m_started = 1'b0;
  // monitor state
  logic [2:0] cap_top [COLS];
  logic [2:0] cap_bot [COLS];
  int  ncol = 0, nrise = 0, nlat = 0, nfall = 0, win = 0;
  int  last_rise = 0, bad_space = 0, t_fall = 0, frame_t0 = -1;
  bit  bad_oe = 0, got_lat = 0, overlap = 0;
  logic p_sclk = 1'b0, p_lat = 1'b0, p_oe_n = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (lat && !oe_n) overlap = 1;
      if (sclk && !p_sclk) begin
        if (ncol > 0 && (cyc - last_rise) != DIV) bad_space++;
        last_rise = cyc;
        if (!oe_n) bad_oe = 1;
        if (ncol < COLS) begin
          cap_top[ncol] = rgb_top;
          cap_bot[ncol] = rgb_bot;
        end
        ncol++;
        nrise++;
      end
      if (lat && !p_lat) begin
        chk(ncol == COLS, "R2 clocks per latch", ncol, COLS);
        chk(!bad_oe, "R2 oe low during shift", bad_oe, 0);
        chk(bad_space == 0, "R3 shift clock spacing", bad_space, 0);
        ncol = 0; bad_space = 0; bad_oe = 0;
        got_lat = 1;
        nlat++;
      end
      if (!oe_n && p_oe_n) begin
        chk(got_lat, "R5 latch before window", got_lat, 1);
        chk(int'(row) == exp_row, "R7 row address", row, exp_row);
        if (exp_row == 0 && exp_plane == 0) begin
          if (frame_t0 >= 0)
            chk(cyc - frame_t0 == FRAME_CYC, "R9 frame period", cyc - frame_t0, FRAME_CYC);
          frame_t0 = cyc;
        end
        got_lat = 0;
        t_fall = cyc;
        nfall++;
      end
      if (oe_n && !p_oe_n) begin
        logic [3*COLS-1:0] at, et, ab, eb;
        int len_exp;
        len_exp = OE_BASE * DIV * (1 << exp_plane);
        chk(cyc - t_fall == len_exp, "R6 window length", cyc - t_fall, len_exp);
        for (int c = 0; c < COLS; c++) begin
          logic [3*PLANES-1:0] pt, pb;
          pt = pix(exp_bank, exp_row, c);
          pb = pix(exp_bank, exp_row + ROWS/2, c);
          for (int ch = 0; ch < 3; ch++) begin
            et[c*3+ch] = pt[ch*PLANES + exp_plane];
            eb[c*3+ch] = pb[ch*PLANES + exp_plane];
          end
          at[c*3 +: 3] = cap_top[c];
          ab[c*3 +: 3] = cap_bot[c];
        end
        chk(at == et, "R4 upper data (R8 bank)", at, et);
        chk(ab == eb, "R4 lower data (R8 bank)", ab, eb);
        chk(!overlap, "R5 latch during window", overlap, 0);
        overlap = 0;
        win++;
        if (exp_plane == PLANES-1) begin
          exp_plane = 0;
          if (exp_row == ROWS/2-1) begin
            exp_row = 0;
            if (m_pend) begin exp_bank = int'(m_latest); m_pend = 0; end
          end else exp_row++;
        end else exp_plane++;
      end
      p_sclk = sclk; p_lat = lat; p_oe_n = oe_n;
    end
  end

  task automatic do_swap();
    @(negedge clk);
    swap = 1'b1;
    m_latest = ~m_latest;
    if (!m_started) begin
      exp_bank = int'(m_latest);
      m_started = 1;
    end else m_pend = 1;
    @(negedge clk);
    swap = 1'b0;
  endtask

  task automatic swap_at(int n);
    wait (nfall >= n);
    repeat (2) @(negedge clk);
    do_swap();
  endtask

  bit done = 0;

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog actual=%0d expected=%0d windows", win, WINDOWS);
          $display("%0d/%0d checks passed", checks - fails, checks);
          $finish;
        end
      end
    join_none

    repeat (4) @(negedge clk);
    chk(oe_n === 1'b1, "R1 reset oe_n", oe_n, 1);
    chk(sclk === 1'b0 && lat === 1'b0, "R1 reset sclk/lat", {sclk, lat}, 0);
    chk(row === '0, "R1 reset row", row, 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    chk(nrise == 0, "R1 no shift before swap", nrise, 0);
    chk(nlat == 0, "R1 no latch before swap", nlat, 0);
    chk(nfall == 0 && oe_n == 1'b1, "R1 dark before swap", nfall, 0);

    do_swap();            // R8: first frame from bank 0
    swap_at(3);           // R8: mid-frame swap, bank 1 from frame 1
    swap_at(20);          // R8: two swaps in frame 1 cancel out
    swap_at(22);
    swap_at(40);          // R8: back to bank 0 from frame 3

    wait (win >= WINDOWS);
    @(negedge clk);
    chk(win == WINDOWS, "R6 window count", win, WINDOWS);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule